// File: doc/BRIEF.md
# Supervisor-Call Trap Status-Word Exchange Sequencer

This block carries out the status-word part of a supervisor-call trap. When a decoded call instruction arrives, it records the condition code and program counter at that moment. It selects one of four trap vectors from the call variant and reads the exchange word stored at that vector. It saves the old status word to the save area that the exchange word points at. It then loads the replacement status word from the next address and adjusts that word using the call's 4-bit R field.

The R field is OR-ed into the loaded condition code. The same field, zero-extended, is added to the loaded program counter only when the exchange word's add-increment flag is set. A software-raised trap request is also handled. It waits as a pending flag until the core reports an interruptible point, and it then runs the same exchange through its own vector with no R-field modification.

Memory traffic uses a single-word request/acknowledge port. Register-block saving is represented only by a one-cycle flag between the store and the load.

Top module: `call_trap_psw`

## Requirements
- R1: Call variant `call_sel` = 0, 1, 2, 3 selects vector 0x48, 0x49, 0x4A, 0x4B. The vector is shown on `vec_addr` while busy and is the address of the first memory read.
- R2: A trap performs, in this order: a read of the vector word, a write of the old status word to the save address (exchange word bits 16:0), the optional register-save flag, a read of the new status word at save address + 1, and then completion. There are no other memory accesses.
- R3: The stored old word holds the condition code sampled at start in bits 31:28 and the return address in bits 16:0. For a call, the return address is the sampled PC + 1 modulo 2^17. All other bits are zero.
- R4: The new word's bits 31:28 equal the loaded condition code bitwise-OR the R field.
- R5: When exchange word bit 22 is 1, the new word's bits 16:0 equal the loaded PC plus the zero-extended R field, modulo 2^17. When bit 22 is 0, they equal the loaded PC. The new word's bits 27:17 are copied from the loaded word.
- R6: `gr_save` is a one-cycle pulse, present only when exchange word bit 31 is 1. It lies after the store is acknowledged and before the load request, with `mem_req` low during the pulse.
- R7: `done` is a one-cycle pulse after the load is acknowledged. `new_psw` is valid from that cycle on and holds until the next completion.
- R8: A `prog_req` pulse sets a pending trap. The trap starts only when the block is idle and `intr_point` is 1. It uses vector 0x47, stores the sampled PC unchanged as the return address, and ignores `r_field`, so the new word equals the loaded word.
- R9: A `call_go` that arrives while busy is ignored. It causes no extra memory access, does not change `vec_addr`, and does not start a trap after completion.
- R10: After synchronous reset, `busy`, `mem_req`, `gr_save` and `done` are 0, and `new_psw` is 0.
- R11: `mem_req` with its address, write enable and write data stays stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_go | input | 1 | Decoded call instruction present |
| call_sel | input | 2 | Call variant 0..3 |
| r_field | input | 4 | R field of the call instruction |
| cur_pc | input | 17 | Address of the call instruction / current PC |
| cur_cc | input | 4 | Condition code before the call |
| prog_req | input | 1 | Software-raised trap request pulse |
| intr_point | input | 1 | Core is at an interruptible point |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 17 | Word address |
| mem_wdata | output | 32 | Write data (old status word) |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| vec_addr | output | 17 | Trap vector of the running trap |
| gr_save | output | 1 | Register-block save step |
| busy | output | 1 | Trap sequence in progress |
| done | output | 1 | Completion pulse |
| new_psw | output | 32 | Modified new status word |

## Verification
The hardest case to reach from the ports is the software-raised trap. It must stay pending and silent while `intr_point` is low, and then run with a nonzero `r_field` on the pins that must have no effect. The bench raises the request, idles several cycles while watching for any memory traffic, and then opens the interruptible point. It does this with an add-increment exchange word, so that any leaked R value would show up in the new word.

A second hard case is a call arriving in mid-sequence. The bench reaches it by pulsing `call_go` with another variant while the first exchange is waiting on a slow acknowledge. It then watches the bus for several idle cycles after completion. Program-counter wraparound is reached by choosing all-ones PCs inside the full sweep over variants, R values, flag settings and acknowledge latencies.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

    localparam int CC_W     = 4;
    localparam int SEL_W    = 2;
    localparam int VEC_W    = 8;
    localparam logic [VEC_W-1:0] CALL_BASE = 8'h48;
    localparam logic [VEC_W-1:0] PROG_VEC  = 8'h47;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_GRSV,
        ST_LOAD,
        ST_MODIFY
    } ctp_state_e;

    typedef struct packed {
        logic            is_prog;
        logic [CC_W-1:0] r_eff;
        logic [CC_W-1:0] cc_before;
    } trap_ctx_t;

    function automatic logic [VEC_W-1:0] call_vector(input logic [SEL_W-1:0] sel);
        return CALL_BASE + {{(VEC_W-SEL_W){1'b0}}, sel};
    endfunction

endpackage

// File: rtl/ctp_trap_arb.sv
module ctp_trap_arb
    import ctp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             call_go,
    input  logic [SEL_W-1:0] call_sel,
    input  logic             prog_req,
    input  logic             intr_point,
    output logic             start,
    output logic             start_prog,
    output logic [VEC_W-1:0] start_vec
);

    logic pend_q;
    logic pend_any;
    logic call_take;
    logic prog_take;

    assign pend_any  = pend_q | prog_req;
    assign call_take = idle & call_go;
    assign prog_take = idle & ~call_go & intr_point & pend_any;

    assign start      = call_take | prog_take;
    assign start_prog = prog_take;
    assign start_vec  = prog_take ? PROG_VEC : call_vector(call_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (prog_take) begin
            pend_q <= 1'b0;
        end else if (prog_req) begin
            pend_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ctp_seq.sv
module ctp_seq
    import ctp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mem_ack,
    input  logic       gr_flag,
    output ctp_state_e state
);

    ctp_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start)   nxt = ST_FETCH;
            ST_FETCH:  if (mem_ack) nxt = ST_STORE;
            ST_STORE:  if (mem_ack) nxt = gr_flag ? ST_GRSV : ST_LOAD;
            ST_GRSV:                nxt = ST_LOAD;
            ST_LOAD:   if (mem_ack) nxt = ST_MODIFY;
            ST_MODIFY:              nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/ctp_psw_calc.sv
module ctp_psw_calc
    import ctp_pkg::*;
#(
    parameter int PC_W   = 17,
    parameter int WORD_W = 32
) (
    input  logic [CC_W-1:0]   r_eff,
    input  logic [CC_W-1:0]   cc_before,
    input  logic [PC_W-1:0]   pc_before,
    input  logic              step_pc,
    input  logic              add_en,
    input  logic [WORD_W-1:0] ld_word,
    output logic [WORD_W-1:0] old_word,
    output logic [WORD_W-1:0] new_word
);

    localparam int CC_LSB = WORD_W - CC_W;

    logic [PC_W-1:0] ret_pc;
    logic [PC_W-1:0] ld_pc;
    logic [CC_W-1:0] ld_cc;
    logic [PC_W-1:0] r_ext;
    logic [PC_W-1:0] pc_sum;

    assign ret_pc = step_pc ? (pc_before + PC_W'(1)) : pc_before;

    always_comb begin
        old_word                  = '0;
        old_word[WORD_W-1:CC_LSB] = cc_before;
        old_word[PC_W-1:0]        = ret_pc;
    end

    assign ld_pc  = ld_word[PC_W-1:0];
    assign ld_cc  = ld_word[WORD_W-1:CC_LSB];
    assign r_ext  = {{(PC_W-CC_W){1'b0}}, r_eff};
    assign pc_sum = add_en ? (ld_pc + r_ext) : ld_pc;

    always_comb begin
        new_word                  = ld_word;
        new_word[WORD_W-1:CC_LSB] = ld_cc | r_eff;
        new_word[PC_W-1:0]        = pc_sum;
    end

endmodule

// File: rtl/call_trap_psw.sv
module call_trap_psw
    import ctp_pkg::*;
#(
    parameter int PC_W   = 17,
    parameter int ADDR_W = 17,
    parameter int WORD_W = 32,
    parameter int AI_POS = 22,
    parameter int GR_POS = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              call_go,
    input  logic [SEL_W-1:0]  call_sel,
    input  logic [CC_W-1:0]   r_field,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [CC_W-1:0]   cur_cc,
    input  logic              prog_req,
    input  logic              intr_point,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              gr_save,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] new_psw
);

    ctp_state_e        state;
    logic              idle;
    logic              start;
    logic              start_prog;
    logic [VEC_W-1:0]  start_vec;

    trap_ctx_t         ctx_q;
    logic [PC_W-1:0]   pc_q;
    logic [VEC_W-1:0]  vec_q;
    logic [ADDR_W-1:0] ea_q;
    logic              ai_q;
    logic              gr_q;
    logic [WORD_W-1:0] ld_q;
    logic [WORD_W-1:0] new_q;
    logic              done_q;

    logic [WORD_W-1:0] old_word;
    logic [WORD_W-1:0] new_word;
    logic [ADDR_W-1:0] vec_ext;

    assign idle = (state == ST_IDLE);

    ctp_trap_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .idle       (idle),
        .call_go    (call_go),
        .call_sel   (call_sel),
        .prog_req   (prog_req),
        .intr_point (intr_point),
        .start      (start),
        .start_prog (start_prog),
        .start_vec  (start_vec)
    );

    ctp_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mem_ack (mem_ack),
        .gr_flag (gr_q),
        .state   (state)
    );

    ctp_psw_calc #(
        .PC_W   (PC_W),
        .WORD_W (WORD_W)
    ) u_calc (
        .r_eff     (ctx_q.r_eff),
        .cc_before (ctx_q.cc_before),
        .pc_before (pc_q),
        .step_pc   (~ctx_q.is_prog),
        .add_en    (ai_q),
        .ld_word   (ld_q),
        .old_word  (old_word),
        .new_word  (new_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
            pc_q  <= '0;
            vec_q <= '0;
        end else if (start) begin
            ctx_q.is_prog   <= start_prog;
            ctx_q.r_eff     <= start_prog ? '0 : r_field;
            ctx_q.cc_before <= cur_cc;
            pc_q            <= cur_pc;
            vec_q           <= start_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_q <= '0;
            ai_q <= 1'b0;
            gr_q <= 1'b0;
        end else if (state == ST_FETCH && mem_ack) begin
            ea_q <= mem_rdata[ADDR_W-1:0];
            ai_q <= mem_rdata[AI_POS];
            gr_q <= mem_rdata[GR_POS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_q <= '0;
        end else if (state == ST_LOAD && mem_ack) begin
            ld_q <= mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            new_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state == ST_MODIFY);
            if (state == ST_MODIFY) begin
                new_q <= new_word;
            end
        end
    end

    assign vec_ext = {{(ADDR_W-VEC_W){1'b0}}, vec_q};

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = vec_ext;
            end
            ST_STORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ea_q;
                mem_wdata = old_word;
            end
            ST_LOAD: begin
                mem_req  = 1'b1;
                mem_addr = ea_q + ADDR_W'(1);
            end
            default: ;
        endcase
    end

    assign vec_addr = vec_ext;
    assign gr_save  = (state == ST_GRSV);
    assign busy     = ~idle;
    assign done     = done_q;
    assign new_psw  = new_q;

endmodule

// File: rtl/call_trap_psw_chk.sv
module call_trap_psw_chk #(
    parameter int ADDR_W = 17,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              gr_save,
    input logic              busy,
    input logic              done
);

    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r6_gr_pulse: assert property (@(posedge clk) disable iff (rst)
        gr_save |=> !gr_save);

    a_r6_gr_no_req: assert property (@(posedge clk) disable iff (rst)
        gr_save |-> (!mem_req && busy));

    a_r1_vec_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (vec_addr >= ADDR_W'(8'h47) && vec_addr <= ADDR_W'(8'h4B)));

    a_r9_vec_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(vec_addr));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !gr_save));

endmodule

bind call_trap_psw call_trap_psw_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .vec_addr  (vec_addr),
    .gr_save   (gr_save),
    .busy      (busy),
    .done      (done)
);

// File: tb/call_trap_psw_tb.sv
`timescale 1ns/1ps
module call_trap_psw_tb;

    localparam int PC_W   = 17;
    localparam int ADDR_W = 17;
    localparam int WORD_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              call_go;
    logic [1:0]        call_sel;
    logic [3:0]        r_field;
    logic [PC_W-1:0]   cur_pc;
    logic [3:0]        cur_cc;
    logic              prog_req;
    logic              intr_point;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata;
    logic              mem_ack;
    logic [WORD_W-1:0] mem_rdata;
    logic [ADDR_W-1:0] vec_addr;
    logic              gr_save;
    logic              busy;
    logic              done;
    logic [WORD_W-1:0] new_psw;

    always #4 clk = ~clk;

    call_trap_psw u_dut (
        .clk        (clk),
        .rst        (rst),
        .call_go    (call_go),
        .call_sel   (call_sel),
        .r_field    (r_field),
        .cur_pc     (cur_pc),
        .cur_cc     (cur_cc),
        .prog_req   (prog_req),
        .intr_point (intr_point),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .vec_addr   (vec_addr),
        .gr_save    (gr_save),
        .busy       (busy),
        .done       (done),
        .new_psw    (new_psw)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model
    logic [WORD_W-1:0] x_word;
    logic [WORD_W-1:0] ld_word;
    int                lat;
    int                wait_left;
    logic [ADDR_W-1:0] tr_addr [4];
    logic              tr_we   [4];
    logic [WORD_W-1:0] tr_wd   [4];
    int                n_tr;
    int                gr_cnt;
    int                gr_pos;

    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (mem_req) begin
            if (wait_left > 0) begin
                wait_left--;
            end else begin
                mem_ack   = 1'b1;
                mem_rdata = (n_tr == 0) ? x_word : ld_word;
                if (n_tr < 4) begin
                    tr_addr[n_tr] = mem_addr;
                    tr_we[n_tr]   = mem_we;
                    tr_wd[n_tr]   = mem_wdata;
                end
                n_tr++;
                wait_left = lat;
            end
        end
        if (gr_save) begin
            gr_cnt++;
            gr_pos = n_tr;
        end
    end

    task automatic run_one(input bit prog, input logic [1:0] sel, input logic [3:0] r,
                           input logic [3:0] cc, input logic [PC_W-1:0] pc,
                           input bit ai, input bit gr, input logic [ADDR_W-1:0] ea,
                           input logic [WORD_W-1:0] ldw, input int l, input bit poke);
        logic [7:0]        exp_vec;
        logic [3:0]        reff;
        logic [WORD_W-1:0] exp_old;
        logic [WORD_W-1:0] exp_new;
        int                t;
        @(negedge clk);
        x_word    = {gr, 8'h00, ai, 5'h15, ea};
        ld_word   = ldw;
        lat       = l;
        wait_left = l;
        n_tr      = 0;
        gr_cnt    = 0;
        gr_pos    = -1;
        cur_pc    = pc;
        cur_cc    = cc;
        r_field   = r;
        call_sel  = sel;
        if (prog) begin
            prog_req = 1'b1;
            @(negedge clk);
            prog_req = 1'b0;
            repeat (3) @(negedge clk);
            chk(!busy && n_tr == 0, "R8 pending trap waits for interruptible point", {63'd0, busy}, 64'd0);
            intr_point = 1'b1;
        end else begin
            call_go = 1'b1;
        end
        @(negedge clk);
        call_go    = 1'b0;
        intr_point = 1'b0;
        exp_vec = prog ? 8'h47 : (8'h48 + {6'd0, sel});
        reff    = prog ? 4'h0 : r;
        chk(busy == 1'b1, "R2 busy after start", {63'd0, busy}, 64'd1);
        chk(vec_addr == ADDR_W'(exp_vec), prog ? "R8 vector" : "R1 vector", vec_addr, exp_vec);
        if (poke) begin
            call_go  = 1'b1;
            call_sel = sel + 2'd1;
            @(negedge clk);
            call_go = 1'b0;
        end
        t = 0;
        while (!done && t < 60) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R7 done seen", {63'd0, done}, 64'd1);
        exp_old = {cc, 11'd0, (prog ? pc : pc + PC_W'(1))};
        exp_new = ldw;
        exp_new[31:28] = ldw[31:28] | reff;
        exp_new[16:0]  = ldw[16:0] + (ai ? {13'd0, reff} : 17'd0);
        chk(n_tr == 3, "R2 access count", n_tr, 3);
        chk(tr_addr[0] == ADDR_W'(exp_vec) && !tr_we[0], "R1 first read at vector", tr_addr[0], exp_vec);
        chk(tr_addr[1] == ea && tr_we[1], "R2 store address", tr_addr[1], ea);
        chk(tr_wd[1] == exp_old, prog ? "R8 stored old word" : "R3 stored old word", tr_wd[1], exp_old);
        chk(tr_addr[2] == ea + ADDR_W'(1) && !tr_we[2], "R2 load address", tr_addr[2], ea + ADDR_W'(1));
        chk(gr_cnt == int'(gr), "R6 register-save pulse count", gr_cnt, gr);
        if (gr) chk(gr_pos == 2, "R6 register-save between store and load", gr_pos, 2);
        chk(new_psw[31:28] == exp_new[31:28], prog ? "R8 cc untouched" : "R4 new cc", new_psw[31:28], exp_new[31:28]);
        chk(new_psw[16:0] == exp_new[16:0], prog ? "R8 pc untouched" : "R5 new pc", new_psw[16:0], exp_new[16:0]);
        chk(new_psw[27:17] == exp_new[27:17], "R5 middle bits copied", new_psw[27:17], exp_new[27:17]);
        chk(vec_addr == ADDR_W'(exp_vec), "R9 vector held", vec_addr, exp_vec);
        @(negedge clk);
        chk(!done && new_psw == exp_new, "R7 single pulse, result held", new_psw, exp_new);
        if (poke) begin
            repeat (4) @(negedge clk);
            chk(!busy && n_tr == 3, "R9 call while busy ignored", n_tr, 3);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        call_go    = 1'b0;
        call_sel   = '0;
        r_field    = '0;
        cur_pc     = '0;
        cur_cc     = '0;
        prog_req   = 1'b0;
        intr_point = 1'b0;
        mem_ack    = 1'b0;
        mem_rdata  = '0;
        x_word     = '0;
        ld_word    = '0;
        lat        = 0;
        wait_left  = 0;
        n_tr       = 0;
        gr_cnt     = 0;
        gr_pos     = -1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req && !gr_save && !done, "R10 reset idle outputs",
            {60'd0, busy, mem_req, gr_save, done}, 64'd0);
        chk(new_psw == '0, "R10 reset new word", new_psw, 64'd0);

        for (int idx = 0; idx < 256; idx++) begin
            logic [PC_W-1:0]   pc;
            logic [PC_W-1:0]   ldpc;
            logic [WORD_W-1:0] ldw;
            pc   = (idx == 255) ? 17'h1FFFF : PC_W'(idx * 517);
            ldpc = (idx[1:0] == 2'b10 && idx > 200) ? 17'h1FFFF : PC_W'(idx * 911);
            ldw  = {4'((idx * 7) % 16), 11'((idx * 13) % 2048), ldpc};
            run_one(1'b0, 2'(idx / 64), 4'((idx / 4) % 16), 4'(idx % 16) ^ 4'h5, pc,
                    idx[1], idx[0], ADDR_W'(17'h100 + idx * 4), ldw, idx % 3, 1'b0);
        end

        run_one(1'b0, 2'd2, 4'h9, 4'h3, 17'h01234, 1'b1, 1'b1, 17'h00800,
                32'h5ABC_1FFF, 3, 1'b1);
        run_one(1'b1, 2'd1, 4'hF, 4'hA, 17'h1FFFF, 1'b1, 1'b1, 17'h00900,
                32'h3000_0042, 1, 1'b0);
        run_one(1'b1, 2'd3, 4'h7, 4'h6, 17'h00010, 1'b0, 1'b0, 17'h00A00,
                32'h0123_4567, 0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule